// File: doc/BRIEF.md
# Binary Rate Multiplier

This block divides a clock stream by a programmable binary rate. A 64-cycle frame counter runs while the block is enabled. On every frame it emits a one-cycle strobe on exactly M of the 64 cycles, where M is a 6-bit rate value. The strobes are interleaved through the frame rather than bunched together. Each bit of M owns a private, evenly spaced set of frame positions. Bit k contributes 2^k positions, and the output is the OR of the bit terms.

The rate is captured on the cycle in which the frame counter sits at zero. Because of this, a change of the rate part way through a frame takes effect only at the next frame. The block has three registered outputs: a true strobe, a complemented copy of it, and a frame-wrap strobe. Typical uses are fractional clock enables, coarse frequency synthesis and low-ripple duty modulation, where each strobe acts as a clock enable for downstream logic.

Top module: `rate_mult`

## Requirements
- R1: An active-low asynchronous reset clears the frame counter to 0 and the captured rate to 0. During reset, pulse_o and wrap_o are low and pulse_no is high.
- R2: Over any fully enabled frame whose captured rate is M, pulse_o is high on exactly M cycles. With M=0 it is never high.
- R3: Bit k of the rate fires at every frame count whose low (6-k) bits are a 0 followed by (5-k) ones. For example, M=1 fires at count 31; M=2 at counts 15 and 47; M=4 at counts 7, 23, 39 and 55.
- R4: The position sets of different rate bits are disjoint, and frame count 63 never produces a pulse.
- R5: wrap_o is high for exactly one cycle per frame. That cycle corresponds to frame count 63 and uses the same output timing as pulse_o.
- R6: pulse_no is always the complement of pulse_o, including during reset.
- R7: The rate is sampled on the enabled cycle in which the counter is 0. A change of rate_i at any other count has no effect on the current frame's pulses.
- R8: While en_i is low, the frame counter holds its value and, from the next edge on, pulse_o and wrap_o are low. When en_i returns high, the frame resumes from the held count.
- R9: The outputs are registered. The strobe decoded for counter value c appears after the rising edge at which the counter held c, and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable; low freezes the frame and blanks the strobes |
| rate_i | input | 6 | Pulses per 64-cycle frame |
| pulse_o | output | 1 | Rate strobe, one cycle wide |
| pulse_no | output | 1 | Complement of pulse_o |
| wrap_o | output | 1 | High for the output cycle of frame count 63 |

## Verification
The assertions assume that en_i and rate_i are synchronous to clk_i and settled before each rising edge. They also assume that reset is applied before any checked behaviour. The bench meets these conditions by changing every input only on the falling edge, and by releasing reset on a falling edge as well. The sweep covers every rate value over one aligned frame. Further runs cover a rate change in mid-frame, a pause with enable low, and a reset applied part way through a frame. The bench's reference model follows the counter through every one of these runs.

// File: rtl/rate_mult_pkg.sv
package rate_mult_pkg;
  parameter int unsigned RM_W = 6;
endpackage

// File: rtl/rm_frame_cnt.sv
module rm_frame_cnt #(
  parameter int unsigned W = rate_mult_pkg::RM_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o,
  output logic         first_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o   = cnt_q;
  assign last_o  = (cnt_q == CNT_MAX);
  assign first_o = (cnt_q == '0);

  // R8
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
  // R5
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q == CNT_MAX) |=> cnt_q == '0);
endmodule

// File: rtl/rm_decode.sv
module rm_decode #(
  parameter int unsigned W = rate_mult_pkg::RM_W
) (
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] rate_i,
  output logic [W-1:0] term_o
);
  for (genvar k = 0; k < W; k++) begin : g_bit
    // low (W-k) bits: a zero above (W-1-k) ones
    localparam int unsigned   SEL_W = W - k;
    localparam logic [W-1:0] PAT   = W'((1 << (W - 1 - k)) - 1);
    assign term_o[k] = rate_i[k] && (cnt_i[SEL_W-1:0] == PAT[SEL_W-1:0]);
  end
endmodule

// File: rtl/rate_mult.sv
module rate_mult #(
  parameter int unsigned W = rate_mult_pkg::RM_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] rate_i,
  output logic         pulse_o,
  output logic         pulse_no,
  output logic         wrap_o
);
  logic [W-1:0] cnt;
  logic         cnt_last, cnt_first;
  logic [W-1:0] rate_q, rate_eff;
  logic [W-1:0] term;
  logic         hit;
  logic         pulse_q, pulse_nq, wrap_q;

  rm_frame_cnt #(.W(W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .cnt_o   (cnt),
    .last_o  (cnt_last),
    .first_o (cnt_first)
  );

  // new rate only enters at the frame start
  assign rate_eff = cnt_first ? rate_i : rate_q;

  rm_decode #(.W(W)) u_dec (
    .cnt_i  (cnt),
    .rate_i (rate_eff),
    .term_o (term)
  );

  assign hit = |term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q   <= '0;
      pulse_q  <= 1'b0;
      pulse_nq <= 1'b1;
      wrap_q   <= 1'b0;
    end else begin
      if (en_i) rate_q <= rate_eff;
      pulse_q  <= en_i & hit;
      pulse_nq <= ~(en_i & hit);
      wrap_q   <= en_i & cnt_last;
    end
  end

  assign pulse_o  = pulse_q;
  assign pulse_no = pulse_nq;
  assign wrap_o   = wrap_q;

  // R4
  term_disjoint_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(term));
  // R4
  wrap_no_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> !pulse_o);
  // R6
  pulse_compl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_no != pulse_o);
  // R8
  en_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!pulse_o && !wrap_o));
  // R7
  rate_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !cnt_first) |=> $stable(rate_q));
endmodule

// File: tb/rate_mult_bench.sv
module rate_mult_bench;
  localparam int W = 6;
  localparam int F = 64;
  localparam time CLK = 4ns;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         en_i = 1'b0;
  logic [W-1:0] rate_i = '0;
  logic         pulse_o, pulse_no, wrap_o;

  int n_cmp = 0;
  int n_bad = 0;
  int mcnt = 0;
  int mrate = 0;
  int last_cnt;
  logic last_pulse;
  logic [F-1:0] seen;
  int tally;

  rate_mult #(.W(W)) u_rate_mult (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .rate_i(rate_i),
    .pulse_o(pulse_o), .pulse_no(pulse_no), .wrap_o(wrap_o)
  );

  always #(CLK/2) clk_i = ~clk_i;

  function automatic bit exp_hit(int c, int r);
    bit h = 0;
    for (int k = 0; k < W; k++)
      if (r[k] && ((c % (F >> k)) == ((F >> (k + 1)) - 1))) h = 1;
    return h;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, check at next negedge
  task automatic step(bit en, int r);
    int  use_rate;
    bit  ep, ew;
    en_i   = en;
    rate_i = W'(r);
    use_rate = (mcnt == 0) ? r : mrate;
    ep = en && exp_hit(mcnt, use_rate);
    ew = en && (mcnt == F - 1);
    last_cnt = mcnt;
    @(posedge clk_i);
    if (en) begin
      mrate = use_rate;
      mcnt  = (mcnt + 1) % F;
    end
    @(negedge clk_i);
    last_pulse = pulse_o;
    if (!en) chk(pulse_o == 0 && wrap_o == 0, "R8 blank", {pulse_o, wrap_o}, 0);
    else     chk(pulse_o == ep, "R3/R9 pulse", pulse_o, ep);
    chk(wrap_o == ew, "R5 wrap", wrap_o, ew);
    chk(pulse_no == !pulse_o, "R6 complement", pulse_no, !pulse_o);
  endtask

  task automatic run_frame(int r);
    seen = '0;
    tally = 0;
    for (int i = 0; i < F; i++) begin
      step(1'b1, r);
      seen[last_cnt] = last_pulse;
      tally += last_pulse;
    end
  endtask

  initial begin
    #(CLK * 200000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(pulse_o == 0 && wrap_o == 0 && pulse_no == 1, "R1 reset",
        {pulse_o, wrap_o, pulse_no}, 3'b001);
    rst_ni = 1'b1;

    // R2 R3 R4: sweep every rate over an aligned frame
    for (int m = 0; m < F; m++) begin
      run_frame(m);
      chk(tally == m, "R2 count", tally, m);
      chk(seen[F-1] == 0, "R4 count63 quiet", seen[F-1], 0);
      if (m == 1) chk(seen == (64'd1 << 31), "R3 M=1", 0, 0);
      if (m == 2) chk(seen == ((64'd1 << 15) | (64'd1 << 47)), "R3 M=2", 0, 0);
      if (m == 3) chk(seen == ((64'd1 << 15) | (64'd1 << 31) | (64'd1 << 47)), "R3 M=3", 0, 0);
      if (m == 4) chk(seen == ((64'd1 << 7) | (64'd1 << 23) | (64'd1 << 39) | (64'd1 << 55)),
                      "R3 M=4", 0, 0);
    end

    // R7: rate change mid-frame ignored
    tally = 0;
    for (int i = 0; i < F; i++) begin
      step(1'b1, (i < 20) ? 5 : 60);
      tally += last_pulse;
    end
    chk(tally == 5, "R7 mid-frame change", tally, 5);
    run_frame(60);
    chk(tally == 60, "R7 next frame takes rate", tally, 60);

    // R8: pause keeps frame position
    tally = 0;
    for (int i = 0; i < 10; i++) begin step(1'b1, 32); tally += last_pulse; end
    for (int i = 0; i < 7; i++) step(1'b0, 9);
    for (int i = 0; i < 54; i++) begin step(1'b1, 32); tally += last_pulse; end
    chk(tally == 32, "R8 resume count", tally, 32);
    chk(mcnt == 0, "R8 frame aligned", mcnt, 0);

    // R1: reset in mid-frame restarts counter and rate
    for (int i = 0; i < 23; i++) step(1'b1, 17);
    rst_ni = 1'b0;
    #1;
    chk(pulse_o == 0 && wrap_o == 0 && pulse_no == 1, "R1 async reset",
        {pulse_o, wrap_o, pulse_no}, 3'b001);
    mcnt = 0; mrate = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_frame(3);
    chk(seen == ((64'd1 << 15) | (64'd1 << 31) | (64'd1 << 47)), "R1 restart at 0", tally, 3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule